// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Unit

This unit sits between the transmit and receive engines of a simple Ethernet link controller and the host. Each engine reports events as single-cycle pulses on a byte-wide event bus. The unit latches every pulse into a sticky status flag. The host reads the flags through a small byte-wide register port. The host clears flags by writing ones to the same address it reads them from.

Each status register has a read/write enable mask. A summary register combines the masked transmit and receive state, a pending DMA-completion flag and three busy levels into one byte. In that byte the interrupt classes are active-low: a pending class reads as 0. The single `irq` output is raised while either the transmit class or the receive class is pending.

Register map (3-bit address): 0 transmit status, 1 transmit mask, 2 receive status, 3 receive mask, 4 summary. Addresses 5 to 7 are unmapped.

Top module: `emac_irq_unit`

## Requirements
- R1: A pulse on bit n of `tx_evt` sets transmit flag n, and the flag stays set until the host clears it. The transmit flags read at address 0, with this bit order: bit 7 frame sent OK, bit 6 carrier sense, bit 5 own frame looped back, bit 4 medium shorted, bit 3 underflow, bit 2 collision, bit 1 sixteenth collision, bit 0 parity error.
- R2: The receive flags read at address 2, with this bit order: bit 7 good frame, bit 4 reset frame, bit 3 runt, bit 2 alignment error, bit 1 CRC error, bit 0 FIFO overflow. Bits 6 and 5 always read 0, whatever is pulsed on `rx_evt` and whatever is written.
- R3: A write to address 0 or 2 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged. Writing 0xFF clears all flags.
- R4: When an event pulse for a flag arrives in the same cycle as a clear write for that flag, the flag ends up set.
- R5: Address 1 holds the 8-bit transmit mask and address 3 holds the 8-bit receive mask. Both read back the value last written.
- R6: Summary bit 0 is 0 while any transmit flag with a set mask bit is 1, and 1 otherwise. Summary bit 1 does the same for the receive flags and receive mask.
- R7: A `dma_done` pulse makes a DMA-done interrupt pending. While it is pending, summary bit 2 reads 0. Any write to address 4 clears it, except that a `dma_done` pulse in the same cycle as that write keeps it pending.
- R8: Summary bits 5, 4 and 3 show the `rx_busy`, `tx_busy` and `dma_busy` inputs in the same cycle. Summary bits 7 and 6 read 0.
- R9: `irq` is 1 exactly when summary bit 0 or summary bit 1 is 0.
- R10: Synchronous reset clears all flags, both masks and the DMA-pending flag.
- R11: Reads have no side effects. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_evt | input | 8 | Transmit event pulses, one per flag |
| rx_evt | input | 8 | Receive event pulses, one per flag |
| dma_done | input | 1 | DMA completion pulse |
| tx_busy | input | 1 | Transmit engine busy level |
| rx_busy | input | 1 | Receive engine busy level |
| dma_busy | input | 1 | DMA engine busy level |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Host interrupt request |

## Verification
Flags, masks and the DMA-pending bit are registers. An event pulse or a write applied before a rising edge therefore shows up on `reg_rdata` and `irq` straight after that edge. The busy bits and the read mux are combinational, so they follow their inputs within the same cycle. The bench drives every input just after a falling edge and lets exactly one rising edge pass. It then samples the outputs shortly after the next falling edge. Combinational-only results are sampled a short delay after the inputs change, with no clock edge in between.

// File: rtl/emac_irq_pkg.sv
package emac_irq_pkg;

    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_TXSTAT = 3'd0,
        A_TXMASK = 3'd1,
        A_RXSTAT = 3'd2,
        A_RXMASK = 3'd3,
        A_SUMM   = 3'd4
    } reg_addr_e;

    // Bits that physically exist in each status register
    localparam logic [DW-1:0] TX_VALID = 8'hFF;
    localparam logic [DW-1:0] RX_VALID = 8'h9F;

    typedef struct packed {
        logic diag;
        logic rsv;
        logic rx_busy;
        logic tx_busy;
        logic dma_busy;
        logic dma_int_n;
        logic rx_int_n;
        logic tx_int_n;
    } summ_t;

    function automatic logic any_pending(input logic [DW-1:0] flags,
                                         input logic [DW-1:0] mask);
        return |(flags & mask);
    endfunction

endpackage

// File: rtl/emac_evt_latch.sv
module emac_evt_latch #(
    parameter int          W     = 8,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] nxt;

    always_comb begin
        clr_vec = clr_en ? clr_bits : '0;
        // event takes priority over a simultaneous clear
        nxt = ((flags & ~clr_vec) | evt) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end
endmodule

// File: rtl/emac_mask_reg.sv
module emac_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/emac_summary.sv
module emac_summary
    import emac_irq_pkg::*;
(
    input  logic [DW-1:0] tx_flags,
    input  logic [DW-1:0] tx_mask,
    input  logic [DW-1:0] rx_flags,
    input  logic [DW-1:0] rx_mask,
    input  logic          dma_pend,
    input  logic          tx_busy,
    input  logic          rx_busy,
    input  logic          dma_busy,
    output summ_t         summ
);
    always_comb begin
        summ           = '0;
        summ.tx_int_n  = ~any_pending(tx_flags, tx_mask);
        summ.rx_int_n  = ~any_pending(rx_flags, rx_mask);
        summ.dma_int_n = ~dma_pend;
        summ.dma_busy  = dma_busy;
        summ.tx_busy   = tx_busy;
        summ.rx_busy   = rx_busy;
    end
endmodule

// File: rtl/emac_irq_unit.sv
module emac_irq_unit
    import emac_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] tx_evt,
    input  logic [DW-1:0] rx_evt,
    input  logic          dma_done,
    input  logic          tx_busy,
    input  logic          rx_busy,
    input  logic          dma_busy,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic [DW-1:0] tx_flags, rx_flags, tx_mask, rx_mask;
    logic          dma_pend;
    summ_t         summ;

    logic wr_txs, wr_txm, wr_rxs, wr_rxm, wr_sum;

    always_comb begin
        wr_txs = reg_wr && (reg_addr == A_TXSTAT);
        wr_txm = reg_wr && (reg_addr == A_TXMASK);
        wr_rxs = reg_wr && (reg_addr == A_RXSTAT);
        wr_rxm = reg_wr && (reg_addr == A_RXMASK);
        wr_sum = reg_wr && (reg_addr == A_SUMM);
    end

    emac_evt_latch #(.W(DW), .VALID(TX_VALID)) u_tx_latch (
        .clk(clk), .rst(rst), .evt(tx_evt), .clr_en(wr_txs),
        .clr_bits(reg_wdata), .flags(tx_flags)
    );

    emac_evt_latch #(.W(DW), .VALID(RX_VALID)) u_rx_latch (
        .clk(clk), .rst(rst), .evt(rx_evt), .clr_en(wr_rxs),
        .clr_bits(reg_wdata), .flags(rx_flags)
    );

    emac_mask_reg #(.W(DW)) u_tx_mask (
        .clk(clk), .rst(rst), .we(wr_txm), .wdata(reg_wdata), .q(tx_mask)
    );

    emac_mask_reg #(.W(DW)) u_rx_mask (
        .clk(clk), .rst(rst), .we(wr_rxm), .wdata(reg_wdata), .q(rx_mask)
    );

    always_ff @(posedge clk) begin
        if (rst)           dma_pend <= 1'b0;
        else if (dma_done) dma_pend <= 1'b1;
        else if (wr_sum)   dma_pend <= 1'b0;
    end

    emac_summary u_summary (
        .tx_flags(tx_flags), .tx_mask(tx_mask),
        .rx_flags(rx_flags), .rx_mask(rx_mask),
        .dma_pend(dma_pend), .tx_busy(tx_busy),
        .rx_busy(rx_busy), .dma_busy(dma_busy),
        .summ(summ)
    );

    always_comb begin
        unique case (reg_addr)
            A_TXSTAT: reg_rdata = tx_flags;
            A_TXMASK: reg_rdata = tx_mask;
            A_RXSTAT: reg_rdata = rx_flags;
            A_RXMASK: reg_rdata = rx_mask;
            A_SUMM:   reg_rdata = summ;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = ~(summ.tx_int_n & summ.rx_int_n);
endmodule

// File: rtl/emac_irq_chk.sv
module emac_irq_chk
    import emac_irq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] tx_evt,
    input logic          dma_done,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [DW-1:0] tx_flags,
    input logic [DW-1:0] tx_mask,
    input logic [DW-1:0] rx_mask,
    input summ_t         summ,
    input logic          irq
);
    AST_TX_SETS: assert property (@(posedge clk) disable iff (rst)
        (|tx_evt) |=> ((tx_flags & $past(tx_evt)) == $past(tx_evt))); // R1

    AST_RX_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_RXSTAT) |-> (reg_rdata[6:5] == 2'b00)); // R2

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_TXSTAT) |=>
        ((tx_flags & $past(reg_wdata) & ~$past(tx_evt)) == '0)); // R3

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_mask == '0 && rx_mask == '0)); // R10

    AST_DMA_PEND: assert property (@(posedge clk) disable iff (rst)
        dma_done |=> !summ.dma_int_n); // R7

    AST_IRQ_SUMM: assert property (@(posedge clk) disable iff (rst)
        irq == (!summ.tx_int_n || !summ.rx_int_n)); // R9
endmodule

bind emac_irq_unit emac_irq_chk u_chk (
    .clk(clk), .rst(rst), .tx_evt(tx_evt), .dma_done(dma_done),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_flags(tx_flags), .tx_mask(tx_mask),
    .rx_mask(rx_mask), .summ(summ), .irq(irq)
);

// File: tb/test_emac_irq_unit.sv
module test_emac_irq_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] tx_evt, rx_evt, reg_wdata, reg_rdata;
    logic       dma_done, tx_busy, rx_busy, dma_busy, reg_wr, irq;
    logic [2:0] reg_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    emac_irq_unit i_emac_irq_unit (
        .clk(clk), .rst(rst), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .dma_done(dma_done), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .dma_busy(dma_busy), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {tx_evt, rx_evt, tx_clr, rx_clr, exp_tx, exp_rx}
    localparam logic [47:0] VEC [6] = '{
        {8'h81, 8'hE0, 8'h00, 8'h00, 8'h81, 8'h80},
        {8'h04, 8'h0F, 8'h80, 8'h00, 8'h05, 8'h8F},
        {8'h00, 8'h10, 8'h01, 8'h88, 8'h04, 8'h17},
        {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00},
        {8'h42, 8'h61, 8'h02, 8'h00, 8'h40, 8'h01},
        {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one clock with the given stimulus, then idle inputs again
    task automatic step(input logic [7:0] tx, input logic [7:0] rx, input logic dma,
                        input logic wr, input logic [2:0] a, input logic [7:0] d);
        tx_evt = tx; rx_evt = rx; dma_done = dma;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        tick();
        tx_evt = '0; rx_evt = '0; dma_done = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        #1;
        check(req, {7'd0, irq}, {7'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_evt = '0; rx_evt = '0; dma_done = 1'b0;
        tx_busy = 1'b0; rx_busy = 1'b0; dma_busy = 1'b0;
        reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        rd("R10 txstat", 3'd0, 8'h00);
        rd("R10 txmask", 3'd1, 8'h00);
        rd("R10 rxstat", 3'd2, 8'h00);
        rd("R10 rxmask", 3'd3, 8'h00);
        rd("R10 summary", 3'd4, 8'h07);
        chk_irq("R10 irq", 1'b0);

        // R1 R2 R3 vector walk
        foreach (VEC[i]) begin
            step(VEC[i][47:40], VEC[i][39:32], 1'b0, 1'b0, 3'd0, 8'h00);
            step(8'h00, 8'h00, 1'b0, 1'b1, 3'd0, VEC[i][31:24]);
            step(8'h00, 8'h00, 1'b0, 1'b1, 3'd2, VEC[i][23:16]);
            rd("R1 R3 tx vector", 3'd0, VEC[i][15:8]);
            rd("R2 R3 rx vector", 3'd2, VEC[i][7:0]);
        end

        // R2: write to unused rx bits
        step(8'h00, 8'h60, 1'b0, 1'b1, 3'd2, 8'h60);
        rd("R2 unused rx bits", 3'd2, 8'h00);

        // R5 masks
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd1, 8'hA5);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd3, 8'h3C);
        rd("R5 txmask", 3'd1, 8'hA5);
        rd("R5 rxmask", 3'd3, 8'h3C);

        // R6 R9 enabled tx flag
        step(8'h80, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        rd("R6 tx unmasked", 3'd4, 8'h06);
        chk_irq("R9 irq tx", 1'b1);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'h80);
        // masked-off tx flag
        step(8'h40, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        rd("R6 tx masked off", 3'd4, 8'h07);
        chk_irq("R9 irq quiet", 1'b0);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'hFF);
        // rx class
        step(8'h00, 8'h04, 1'b0, 1'b0, 3'd0, 8'h00);
        rd("R6 rx unmasked", 3'd4, 8'h05);
        chk_irq("R9 irq rx", 1'b1);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd2, 8'hFF);
        rd("R6 rx cleared", 3'd4, 8'h07);

        // R4 event beats clear
        step(8'h02, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        step(8'h04, 8'h00, 1'b0, 1'b1, 3'd0, 8'hFF);
        rd("R4 same-cycle set", 3'd0, 8'h04);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd0, 8'hFF);

        // R7 dma pending
        step(8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        rd("R7 dma pending", 3'd4, 8'h03);
        chk_irq("R7 R9 dma not irq", 1'b0);
        step(8'h00, 8'h00, 1'b1, 1'b1, 3'd4, 8'h00);
        rd("R7 dma beats clear", 3'd4, 8'h03);
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd4, 8'h00);
        rd("R7 dma cleared", 3'd4, 8'h07);

        // R8 busy levels (combinational)
        tx_busy = 1'b1; rx_busy = 1'b1;
        rd("R8 rx tx busy", 3'd4, 8'h37);
        tx_busy = 1'b0; rx_busy = 1'b0; dma_busy = 1'b1;
        rd("R8 dma busy", 3'd4, 8'h0F);
        dma_busy = 1'b0;

        // R11 unmapped and side-effect free reads
        step(8'h00, 8'h00, 1'b0, 1'b1, 3'd5, 8'hFF);
        rd("R11 unmapped", 3'd5, 8'h00);
        rd("R11 mask intact", 3'd1, 8'hA5);
        step(8'h10, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        tick();
        rd("R11 read keeps flag", 3'd0, 8'h10);
        rd("R11 read keeps flag again", 3'd0, 8'h10);

        // R10 reset mid-run
        rst = 1'b1; tick(); rst = 1'b0;
        rd("R10 txstat after", 3'd0, 8'h00);
        rd("R10 txmask after", 3'd1, 8'h00);
        rd("R10 rxmask after", 3'd3, 8'h00);
        rd("R10 summary after", 3'd4, 8'h07);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule